// File: doc/BRIEF.md
# Early Branch Resolver with Static Direction Guess

This unit looks at every entry of an instruction dispatch queue in each cycle and picks out the oldest valid branch. It does not wait for the branch to reach an execute stage. When it accepts a branch, it works out the branch destination from the branch address and a signed word offset. It then decides the direction straight away.

If the condition field the branch tests already holds a settled value, that value decides the direction and no guessing takes place. A taken branch sends the fetch unit to the destination in the next cycle. A not-taken branch lets sequential fetch continue. If the field is still unsettled, a static rule makes the choice: a negative offset (a jump backward) is guessed taken, and a positive offset is guessed not taken.

While a guess is open, the unit raises a speculation flag so that later instructions are dispatched as cancellable. It also accepts no further branch. A resolution port later reports the true outcome of a condition field. If the outcome agrees with the guess, the flag simply drops. If it disagrees, the unit raises a one-cycle flush and steers fetch to the correct address: the destination, or the address that follows the branch.

Top module: `branch_resolve_predict`

## Requirements
- R1: Among entries with both the valid bit and the branch bit set, the lowest index is accepted. `br_ack` is one-hot at that index, in the same cycle. Entries that are not branches, and branch entries whose valid bit is clear, are never accepted.
- R2: While `spec_tag` is high, `br_ack` stays zero, even when a branch is present in the queue.
- R3: The destination equals the branch PC plus the sign-extended offset multiplied by four, with wraparound at the PC width. This includes the most negative offset.
- R4: If the tested field is marked settled and its bit is 1, the cycle after acceptance shows `redir_valid` high with `redir_pc` equal to the destination. `spec_tag` stays low.
- R5: If the tested field is settled and its bit is 0, acceptance produces no redirect and `spec_tag` stays low.
- R6: If the tested field is unsettled and the offset is negative, the cycle after acceptance shows a redirect to the destination, and `spec_tag` is high.
- R7: If the tested field is unsettled and the offset is zero or positive, the cycle after acceptance shows no redirect, and `spec_tag` is high.
- R8: While `spec_tag` is high, a resolution of the pending field that agrees with the guess clears `spec_tag` in the next cycle, with no flush and no redirect.
- R9: A resolution of the pending field that disagrees with the guess gives, in the next cycle, `flush` high for exactly one cycle, `redir_valid` high, and `spec_tag` low. `redir_pc` is the destination if the true outcome is taken, or the branch PC plus 4 if it is not.
- R10: A resolution that names a different field, or that arrives while nothing is pending, changes none of the outputs.
- R11: After reset, `spec_tag`, `flush` and `redir_valid` are low, and `redir_pc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | DEPTH | Per-entry valid; index 0 is oldest |
| q_branch | input | DEPTH | Per-entry branch marker |
| q_pc | input | DEPTH*PCW | Entry addresses, entry i at bits [i*PCW +: PCW] |
| q_disp | input | DEPTH*DISPW | Signed word offsets, packed the same way |
| q_field | input | DEPTH*FW | Index of the condition field each branch tests |
| cc_bits | input | CRF | Condition field values, 1 means taken |
| cc_known | input | CRF | Per-field settled flags |
| res_valid | input | 1 | Late outcome report strobe |
| res_field | input | FW | Field the outcome belongs to |
| res_taken | input | 1 | True outcome of that field |
| br_ack | output | DEPTH | One-hot acceptance of a queue entry |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_pc | output | PCW | Redirect address |
| spec_tag | output | 1 | Guess open; later dispatches are conditional |
| flush | output | 1 | Cancel all conditional work |

## Verification
The bench builds the unit with four queue entries, eight condition fields, 32-bit addresses and a 14-bit offset. The narrow offset lets directed stimulus reach the most negative offset and the wraparound of the destination. Four entries are enough to place branches behind non-branch entries and behind invalid branch entries. Eight fields leave room to report outcomes for a field other than the pending one. A random phase mixes settled and unsettled fields with stray resolutions, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/branch_resolve_predict.sv
module branch_resolve_predict #(
  parameter int DEPTH = 4,
  parameter int PCW   = 32,
  parameter int DISPW = 14,
  parameter int CRF   = 8,
  localparam int FW   = (CRF > 1) ? $clog2(CRF) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DEPTH-1:0]       q_valid,
  input  logic [DEPTH-1:0]       q_branch,
  input  logic [DEPTH*PCW-1:0]   q_pc,
  input  logic [DEPTH*DISPW-1:0] q_disp,
  input  logic [DEPTH*FW-1:0]    q_field,
  input  logic [CRF-1:0]         cc_bits,
  input  logic [CRF-1:0]         cc_known,
  input  logic                   res_valid,
  input  logic [FW-1:0]          res_field,
  input  logic                   res_taken,
  output logic [DEPTH-1:0]       br_ack,
  output logic                   redir_valid,
  output logic [PCW-1:0]         redir_pc,
  output logic                   spec_tag,
  output logic                   flush
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             sel_hit;
  logic [IW-1:0]    sel_idx;
  logic [PCW-1:0]   sel_pc, target;
  logic [DISPW-1:0] sel_disp;
  logic [FW-1:0]    sel_fld;
  logic             go, resolve, miss;

  logic             pend, pend_pred;
  logic [FW-1:0]    pend_fld;
  logic [PCW-1:0]   pend_tgt, pend_seq;

  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (q_valid[i] && q_branch[i]) begin
        sel_hit = 1'b1;
        sel_idx = IW'(i);
      end
  end

  assign sel_pc   = q_pc[sel_idx*PCW +: PCW];
  assign sel_disp = q_disp[sel_idx*DISPW +: DISPW];
  assign sel_fld  = q_field[sel_idx*FW +: FW];
  assign target   = sel_pc + {{(PCW-DISPW-2){sel_disp[DISPW-1]}}, sel_disp, 2'b00};

  assign go      = sel_hit && !pend;
  assign br_ack  = go ? (DEPTH'(1) << sel_idx) : '0;
  assign resolve = pend && res_valid && (res_field == pend_fld);
  assign miss    = resolve && (res_taken != pend_pred);
  assign spec_tag = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend        <= 1'b0;
      pend_pred   <= 1'b0;
      pend_fld    <= '0;
      pend_tgt    <= '0;
      pend_seq    <= '0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      flush       <= 1'b0;
    end else begin
      redir_valid <= 1'b0;
      flush       <= 1'b0;
      if (resolve) begin
        pend <= 1'b0;
        if (miss) begin
          flush       <= 1'b1;
          redir_valid <= 1'b1;
          redir_pc    <= res_taken ? pend_tgt : pend_seq;
        end
      end else if (go) begin
        if (cc_known[sel_fld]) begin
          if (cc_bits[sel_fld]) begin
            redir_valid <= 1'b1;
            redir_pc    <= target;
          end
        end else begin
          pend      <= 1'b1;
          pend_pred <= sel_disp[DISPW-1];
          pend_fld  <= sel_fld;
          pend_tgt  <= target;
          pend_seq  <= sel_pc + PCW'(4);
          if (sel_disp[DISPW-1]) begin
            redir_valid <= 1'b1;
            redir_pc    <= target;
          end
        end
      end
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(br_ack)); // R1
  AST_NO_ACK_WHILE_SPEC: assert property (@(posedge clk) disable iff (!rst_n) spec_tag |-> br_ack == '0); // R2
  AST_SPEC_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n) $rose(spec_tag) |-> $past(br_ack != '0)); // R6
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !flush); // R9
  AST_FLUSH_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n) flush |-> redir_valid && !spec_tag && $past(spec_tag)); // R9
endmodule

// File: tb/tb_branch_resolve_predict.sv
`timescale 1ns/1ps
module tb_branch_resolve_predict;
  localparam int D = 4, PW = 32, DW = 14, NF = 8, FW = 3;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [D-1:0] qv, qb;
  logic [PW-1:0] qpc [D];
  logic [DW-1:0] qdisp [D];
  logic [FW-1:0] qfld [D];
  logic [D*PW-1:0] f_pc;
  logic [D*DW-1:0] f_disp;
  logic [D*FW-1:0] f_fld;
  logic [NF-1:0] ccb, cck;
  logic rv, rtk;
  logic [FW-1:0] rf;
  logic [D-1:0] ack;
  logic redv, spec, fl;
  logic [PW-1:0] redpc;

  always_comb
    for (int i = 0; i < D; i++) begin
      f_pc[i*PW +: PW] = qpc[i];
      f_disp[i*DW +: DW] = qdisp[i];
      f_fld[i*FW +: FW] = qfld[i];
    end

  branch_resolve_predict #(.DEPTH(D), .PCW(PW), .DISPW(DW), .CRF(NF)) dut (
    .clk(clk), .rst_n(rst_n), .q_valid(qv), .q_branch(qb), .q_pc(f_pc),
    .q_disp(f_disp), .q_field(f_fld), .cc_bits(ccb), .cc_known(cck),
    .res_valid(rv), .res_field(rf), .res_taken(rtk), .br_ack(ack),
    .redir_valid(redv), .redir_pc(redpc), .spec_tag(spec), .flush(fl));

  int checks = 0, errors = 0;
  string cur_req = "R11";

  bit m_pend, m_pred, m_rv, m_fl;
  logic [FW-1:0] m_fld;
  logic [PW-1:0] m_tgt, m_seq, m_rpc;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic clear_q();
    for (int i = 0; i < D; i++) begin
      qpc[i] = 32'h100 * i; qdisp[i] = '0; qfld[i] = '0;
    end
    qv = '0; qb = '0; rv = 0; rf = '0; rtk = 0;
  endtask

  task automatic check_regs();
    chk(spec === m_pend, "spec_tag", 64'(spec), 64'(m_pend));
    chk(redv === m_rv, "redir_valid", 64'(redv), 64'(m_rv));
    chk(fl === m_fl, "flush", 64'(fl), 64'(m_fl));
    if (m_rv) chk(redpc === m_rpc, "redir_pc", 64'(redpc), 64'(m_rpc));
  endtask

  task automatic step();
    int sel;
    logic [D-1:0] eack;
    bit n_pend, n_pred, n_rv, n_fl;
    logic [FW-1:0] n_fld;
    logic [PW-1:0] n_tgt, n_seq, n_rpc, tg;
    logic signed [DW-1:0] sd;
    int di;
    #1;
    sel = -1;
    for (int i = 0; i < D; i++) if (sel < 0 && qv[i] && qb[i]) sel = i;
    eack = (sel >= 0 && !m_pend) ? D'(1) << sel : '0;
    chk(ack === eack, "br_ack", 64'(ack), 64'(eack));
    n_pend = m_pend; n_pred = m_pred; n_fld = m_fld; n_tgt = m_tgt; n_seq = m_seq;
    n_rv = 0; n_fl = 0; n_rpc = m_rpc;
    if (m_pend && rv && rf == m_fld) begin
      n_pend = 0;
      if (rtk != m_pred) begin
        n_fl = 1; n_rv = 1; n_rpc = rtk ? m_tgt : m_seq;
      end
    end else if (eack != 0) begin
      sd = qdisp[sel]; di = sd;
      tg = qpc[sel] + 32'(di * 4);
      if (cck[qfld[sel]]) begin
        if (ccb[qfld[sel]]) begin n_rv = 1; n_rpc = tg; end
      end else begin
        n_pend = 1; n_pred = (di < 0); n_fld = qfld[sel];
        n_tgt = tg; n_seq = qpc[sel] + 32'd4;
        if (di < 0) begin n_rv = 1; n_rpc = tg; end
      end
    end
    @(posedge clk);
    m_pend = n_pend; m_pred = n_pred; m_fld = n_fld; m_tgt = n_tgt; m_seq = n_seq;
    m_rv = n_rv; m_fl = n_fl; m_rpc = n_rpc;
    @(negedge clk);
    check_regs();
  endtask

  task automatic put(input int idx, input logic [PW-1:0] pc, input logic [DW-1:0] d, input logic [FW-1:0] f);
    qv[idx] = 1; qb[idx] = 1; qpc[idx] = pc; qdisp[idx] = d; qfld[idx] = f;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_q(); ccb = '0; cck = '0;
    m_pend = 0; m_pred = 0; m_fld = '0; m_tgt = '0; m_seq = '0; m_rv = 0; m_fl = 0; m_rpc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R11";
    check_regs();
    chk(redpc === '0, "redir_pc reset", 64'(redpc), 0);

    cur_req = "R1";
    qv[0] = 1; qb[0] = 0; qb[1] = 1; qv[1] = 0;
    put(2, 32'h1000, 14'd5, 3'd3); put(3, 32'h5000, 14'd1, 3'd3);
    cck[3] = 1; ccb[3] = 1;
    step();
    cur_req = "R4"; clear_q(); step();

    cur_req = "R5"; ccb[3] = 0; put(1, 32'h2000, 14'd7, 3'd3); step();
    clear_q(); step();

    cur_req = "R3"; ccb[3] = 1; put(0, 32'h8000, 14'h2000, 3'd3); step();
    put(0, 32'h4, 14'h3FFE, 3'd3); step();
    clear_q(); step();

    cur_req = "R6"; put(0, 32'h2000, -14'sd3, 3'd2); step();
    cur_req = "R2"; put(1, 32'h2100, 14'd2, 3'd3); step(); step();
    cur_req = "R8"; clear_q(); rv = 1; rf = 3'd2; rtk = 1; step();
    rv = 0; step();

    cur_req = "R7"; put(0, 32'h3000, 14'd8, 3'd5); step();
    cur_req = "R10"; clear_q(); rv = 1; rf = 3'd4; rtk = 1; step();
    cur_req = "R9"; rf = 3'd5; step();
    rv = 0; step();

    cur_req = "R9"; put(2, 32'h6000, -14'sd16, 3'd1); step();
    clear_q(); rv = 1; rf = 3'd1; rtk = 0; step();
    rv = 0; step();
    cur_req = "R8"; put(0, 32'h7000, 14'd4, 3'd6); step();
    clear_q(); rv = 1; rf = 3'd6; rtk = 0; step();
    cur_req = "R10"; rtk = 1; step();
    rv = 0; step();

    cur_req = "random";
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < D; i++) begin
        qpc[i] = $urandom & 32'hFFFF_FFFC; qdisp[i] = DW'($urandom); qfld[i] = FW'($urandom);
      end
      qv = D'($urandom); qb = D'($urandom);
      ccb = NF'($urandom); cck = NF'($urandom);
      rv = ($urandom % 3) == 0; rf = FW'($urandom); rtk = 1'($urandom);
      step();
    end
    clear_q(); step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule